// File: doc/BRIEF.md
# Multi-Operand Carry-Save Adder Tree

This block adds a parameterised set of unsigned operand buses in a single pass. All `SIZE` operands of `WIDTH` bits arrive packed on one input bus, with operand i in bits `[i*WIDTH +: WIDTH]`. Their bits are gathered into weight columns. The columns are then cut down to two rows by a Dadda schedule of full and half adders. The target heights run 2, 3, 4, 6, 9, 13, 19, 28, 42, 63. Each stage trims a column only as far as the next lower target, so the tree uses fewer counters than a cascade of two-operand adders and has a shorter carry path.

The variant is chosen at build time with `MODE`:

- **Combinational.** A final carry-propagate adder resolves the two rows into `sum` in the same cycle.
- **Pipelined.** One register sits between the tree and the final adder, so the result appears one active clock edge after it is accepted. `CLK_FALL` selects the rising or the falling edge.
- **Redundant output.** There is no final adder. The two rows leave on `sum_a` and `sum_b`, and the next cascaded stage can resolve the carries.

Operands enter under a valid/ready handshake and results leave under one. A transfer happens only on an active edge where valid and ready are both high. In the combinational and redundant variants, the handshake passes straight through. In the pipelined variant, the register slot accepts new data when it is empty or when the held result is being taken in the same cycle. While the held result is refused downstream, the slot stalls the producer and freezes its output.

The sum width is `OUTW = ceil(log2(SIZE*(2^WIDTH-1)+1))`, at most `WIDTH + ceil(log2(SIZE))`. The parameters must satisfy `SIZE >= 3` and `WIDTH >= 2`, with up to 64 of each supported.

Top module: `multi_operand_adder`

## Requirements
- R1: In the combinational variant (`MODE` = ARR_COMB), `sum` equals the unsigned total of all `SIZE` operands in the same cycle, with operand i taken from `operands[i*WIDTH +: WIDTH]`.
- R2: `sum`, `sum_a` and `sum_b` are each `OUTW = ceil(log2(SIZE*(2^WIDTH-1)+1))` bits wide: 12 bits for WIDTH=8, SIZE=9, and 4 bits for WIDTH=2, SIZE=5. The all-ones input gives the largest total, which is exactly representable.
- R3: In the combinational and redundant variants, `out_valid` follows `in_valid` and `in_ready` follows `out_ready` with no register between them.
- R4: In the pipelined variant (`MODE` = ARR_PIPE), a transfer (`in_valid && in_ready` at an active edge) is followed, after that edge, by `out_valid` = 1 and `sum` = the total of the operands transferred.
- R5: In the pipelined variant, while `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0, and `out_valid` and `sum` hold their values across the edge. No new operand set is taken in.
- R6: In the pipelined variant, when `in_ready` = 1 and `in_valid` = 0 at an active edge, `out_valid` is 0 after that edge.
- R7: In the redundant variant (`MODE` = ARR_CSA), the sum `sum_a + sum_b`, formed one bit wider than `OUTW`, equals the operand total and never needs that extra bit.
- R8: Outputs that a variant does not use are held at zero: `sum` in the redundant variant, and `sum_a` and `sum_b` in the two variants that have a final adder.
- R9: With `CLK_FALL` = 1, the pipelined variant takes in data on the falling edge of `clk`. With `CLK_FALL` = 0, it takes in data on the rising edge.
- R10: `rst_n` is an asynchronous active-low reset. While it is low and after it is released, the pipelined variant shows `out_valid` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used by the pipelined variant only |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set on `operands` is valid |
| in_ready | output | 1 | Block can take the operand set this cycle |
| operands | input | SIZE*WIDTH | Packed operands; operand i at bits [i*WIDTH +: WIDTH] |
| out_valid | output | 1 | Result outputs carry a valid result |
| out_ready | input | 1 | Downstream takes the result this cycle |
| sum | output | OUTW | Resolved total (zero in the redundant variant) |
| sum_a | output | OUTW | First redundant row (zero unless redundant variant) |
| sum_b | output | OUTW | Second redundant row (zero unless redundant variant) |

## Verification
The all-ones operand set is the key corner case. A width rule that drops a bit, or a tree that loses a carry from the top column, would return a total with its top bit missing. A single full-scale operand next to zeros checks that each column's weight is kept apart; a mis-sliced operand would land its bits in the wrong columns. A stall with `out_ready` low, while new operands wait at the input, catches a slot that overwrites its held result. Running the falling-edge build beside the rising-edge one shows whether the edge choice takes effect: a build that ignores it would update half a cycle late. Summing `sum_a + sum_b` one bit wider catches a redundant pair that overflows `OUTW`.

// File: rtl/arr_add_pkg.sv
package arr_add_pkg;

  typedef enum logic [1:0] {
    ARR_COMB = 2'd0,
    ARR_PIPE = 2'd1,
    ARR_CSA  = 2'd2
  } arr_mode_e;

  // Smallest width that holds size * (2^width - 1).
  function automatic int sum_width(int size, int width);
    int k;
    k = $clog2(size);
    if (width >= 7) return width + k;
    if ((size - (1 << (k - 1))) * (1 << width) < size) return width + k - 1;
    return width + k;
  endfunction

  // Height limit idx of the reduction schedule: 2, 3, 4, 6, 9, 13, ...
  function automatic int dadda_limit(int idx);
    int d;
    d = 2;
    for (int i = 0; i < idx; i++) d = (d * 3) / 2;
    return d;
  endfunction

  // Number of limits strictly below the starting column height.
  function automatic int dadda_stages(int size);
    int n;
    n = 0;
    for (int i = 0; i < 16; i++)
      if (dadda_limit(i) < size) n = i + 1;
    return n;
  endfunction

  // Target height of stage s, counted from the tree input.
  function automatic int dadda_target(int size, int s);
    return dadda_limit(dadda_stages(size) - 1 - s);
  endfunction

endpackage

// File: rtl/mo_csa_tree.sv
module mo_csa_tree
  import arr_add_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SIZE  = 12,
  parameter int OUTW  = 20
) (
  input  logic [SIZE*WIDTH-1:0] operands,
  output logic [OUTW-1:0]       row_a,
  output logic [OUTW-1:0]       row_b
);

  localparam int NST  = dadda_stages(SIZE);
  localparam int MAXH = SIZE;

  logic mat [OUTW][MAXH];
  logic nxt [OUTW][MAXH];
  int   hgt [OUTW];
  int   nh  [OUTW];
  int   tgt, ex, nfa, nha, p;
  logic x0, x1, x2;

  always_comb begin
    tgt = 0; ex = 0; nfa = 0; nha = 0; p = 0;
    x0 = 1'b0; x1 = 1'b0; x2 = 1'b0;
    for (int c = 0; c < OUTW; c++) begin
      hgt[c] = (c < WIDTH) ? SIZE : 0;
      nh[c]  = 0;
      for (int k = 0; k < MAXH; k++) begin
        mat[c][k] = (c < WIDTH) ? operands[k*WIDTH + c] : 1'b0;
        nxt[c][k] = 1'b0;
      end
    end

    for (int s = 0; s < NST; s++) begin
      tgt = dadda_target(SIZE, s);
      for (int c = 0; c < OUTW; c++) begin
        nh[c] = 0;
        for (int k = 0; k < MAXH; k++) nxt[c][k] = 1'b0;
      end
      for (int c = 0; c < OUTW; c++) begin
        // nh[c] already holds the carries that column c-1 pushed up
        ex  = hgt[c] + nh[c] - tgt;
        nfa = (ex > 0) ? ex / 2 : 0;
        nha = (ex > 0) ? ex % 2 : 0;
        p   = 0;
        for (int k = 0; k < MAXH; k++) begin
          if (k < nfa) begin
            x0 = mat[c][p];
            x1 = mat[c][p+1];
            x2 = mat[c][p+2];
            nxt[c][nh[c]] = x0 ^ x1 ^ x2;
            nh[c] = nh[c] + 1;
            if (c + 1 < OUTW) begin
              nxt[c+1][nh[c+1]] = (x0 & x1) | (x0 & x2) | (x1 & x2);
              nh[c+1] = nh[c+1] + 1;
            end
            p = p + 3;
          end
        end
        if (nha != 0) begin
          x0 = mat[c][p];
          x1 = mat[c][p+1];
          nxt[c][nh[c]] = x0 ^ x1;
          nh[c] = nh[c] + 1;
          if (c + 1 < OUTW) begin
            nxt[c+1][nh[c+1]] = x0 & x1;
            nh[c+1] = nh[c+1] + 1;
          end
          p = p + 2;
        end
        for (int k = 0; k < MAXH; k++) begin
          if (k >= p && k < hgt[c]) begin
            nxt[c][nh[c]] = mat[c][k];
            nh[c] = nh[c] + 1;
          end
        end
      end
      mat = nxt;
      hgt = nh;
    end

    for (int c = 0; c < OUTW; c++) begin
      row_a[c] = mat[c][0];
      row_b[c] = mat[c][1];
    end
  end

endmodule

// File: rtl/mo_final_adder.sv
module mo_final_adder #(
  parameter int OUTW = 20
) (
  input  logic [OUTW-1:0] a,
  input  logic [OUTW-1:0] b,
  output logic [OUTW-1:0] sum
);

  // The two rows never carry out of OUTW bits, so the top carry is not kept.
  assign sum = a + b;

endmodule

// File: rtl/mo_pipe_reg.sv
module mo_pipe_reg #(
  parameter int OUTW     = 20,
  parameter bit CLK_FALL = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OUTW-1:0] a_in,
  input  logic [OUTW-1:0] b_in,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OUTW-1:0] a_q,
  output logic [OUTW-1:0] b_q
);

  logic vld_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;

  if (CLK_FALL) begin : g_fall
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        a_q   <= '0;
        b_q   <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) begin
          a_q <= a_in;
          b_q <= b_in;
        end
      end
    end
  end else begin : g_rise
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        a_q   <= '0;
        b_q   <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) begin
          a_q <= a_in;
          b_q <= b_in;
        end
      end
    end
  end

endmodule

// File: rtl/multi_operand_adder.sv
module multi_operand_adder
  import arr_add_pkg::*;
#(
  parameter int        WIDTH    = 16,
  parameter int        SIZE     = 12,
  parameter arr_mode_e MODE     = ARR_PIPE,
  parameter bit        CLK_FALL = 1'b0,
  localparam int       OUTW     = sum_width(SIZE, WIDTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [SIZE*WIDTH-1:0] operands,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [OUTW-1:0]       sum,
  output logic [OUTW-1:0]       sum_a,
  output logic [OUTW-1:0]       sum_b
);

  logic [OUTW-1:0] row_a, row_b;

  mo_csa_tree #(.WIDTH(WIDTH), .SIZE(SIZE), .OUTW(OUTW)) u_tree (
    .operands(operands),
    .row_a   (row_a),
    .row_b   (row_b)
  );

  if (MODE == ARR_PIPE) begin : g_pipe
    logic [OUTW-1:0] a_q, b_q;

    mo_pipe_reg #(.OUTW(OUTW), .CLK_FALL(CLK_FALL)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .a_in     (row_a),
      .b_in     (row_b),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .a_q      (a_q),
      .b_q      (b_q)
    );

    mo_final_adder #(.OUTW(OUTW)) u_cpa (.a(a_q), .b(b_q), .sum(sum));
    assign sum_a = '0;
    assign sum_b = '0;
  end else if (MODE == ARR_COMB) begin : g_comb
    logic ctl_unused;
    assign ctl_unused = clk ^ rst_n;

    mo_final_adder #(.OUTW(OUTW)) u_cpa (.a(row_a), .b(row_b), .sum(sum));
    assign out_valid = in_valid;
    assign in_ready  = out_ready;
    assign sum_a     = '0;
    assign sum_b     = '0;
  end else begin : g_csa
    logic ctl_unused;
    assign ctl_unused = clk ^ rst_n;

    assign sum       = '0;
    assign sum_a     = row_a;
    assign sum_b     = row_b;
    assign out_valid = in_valid;
    assign in_ready  = out_ready;
  end

endmodule

// File: rtl/multi_operand_adder_chk.sv
module multi_operand_adder_chk
  import arr_add_pkg::*;
#(
  parameter int        WIDTH    = 16,
  parameter int        SIZE     = 12,
  parameter arr_mode_e MODE     = ARR_PIPE,
  parameter bit        CLK_FALL = 1'b0,
  localparam int       OUTW     = sum_width(SIZE, WIDTH)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [SIZE*WIDTH-1:0] operands,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [OUTW-1:0]       sum,
  input logic [OUTW-1:0]       sum_a,
  input logic [OUTW-1:0]       sum_b
);

  logic act_clk;
  assign act_clk = CLK_FALL ? ~clk : clk;

  logic chk_unused;
  assign chk_unused = ^{in_ready, out_valid, out_ready, sum, sum_a, sum_b};

  function automatic logic [OUTW:0] total(input logic [SIZE*WIDTH-1:0] v);
    logic [OUTW:0] acc;
    logic [OUTW:0] term;
    acc = '0;
    for (int i = 0; i < SIZE; i++) begin
      term = '0;
      term[WIDTH-1:0] = v[i*WIDTH +: WIDTH];
      acc = acc + term;
    end
    return acc;
  endfunction

  if (MODE == ARR_COMB) begin : g_comb
    assert_sum_matches_R1: assert property (@(posedge act_clk) disable iff (!rst_n)
      in_valid |-> ({1'b0, sum} == total(operands)));
  end else if (MODE == ARR_PIPE) begin : g_pipe
    assert_pipe_result_R4: assert property (@(posedge act_clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && ({1'b0, sum} == $past(total(operands)))));
    assert_stall_hold_R5: assert property (@(posedge act_clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(sum)));
    assert_drain_R6: assert property (@(posedge act_clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> !out_valid);
  end else begin : g_csa
    assert_no_overflow_R7: assert property (@(posedge act_clk) disable iff (!rst_n)
      in_valid |-> (({1'b0, sum_a} + {1'b0, sum_b}) == total(operands)));
  end

endmodule

bind multi_operand_adder multi_operand_adder_chk #(
  .WIDTH(WIDTH), .SIZE(SIZE), .MODE(MODE), .CLK_FALL(CLK_FALL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .operands(operands), .out_valid(out_valid), .out_ready(out_ready),
  .sum(sum), .sum_a(sum_a), .sum_b(sum_b)
);

// File: tb/multi_operand_adder_test.sv
module multi_operand_adder_test;
  import arr_add_pkg::*;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        out_ready = 1'b1;
  logic [71:0] ops_w = '0;
  logic [9:0]  ops_t = '0;

  logic        rdy_p, vld_p, rdy_f, vld_f, rdy_c, vld_c, rdy_s, vld_s, rdy_t, vld_t;
  logic [11:0] sum_p, sa_p, sb_p, sum_f, sa_f, sb_f, sum_c, sa_c, sb_c, sum_s, sa_s, sb_s;
  logic [3:0]  sum_t, sa_t, sb_t;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  multi_operand_adder #(.WIDTH(8), .SIZE(9), .MODE(ARR_PIPE), .CLK_FALL(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_p), .operands(ops_w),
    .out_valid(vld_p), .out_ready(out_ready), .sum(sum_p), .sum_a(sa_p), .sum_b(sb_p));
  multi_operand_adder #(.WIDTH(8), .SIZE(9), .MODE(ARR_PIPE), .CLK_FALL(1'b1)) uut_fall (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_f), .operands(ops_w),
    .out_valid(vld_f), .out_ready(out_ready), .sum(sum_f), .sum_a(sa_f), .sum_b(sb_f));
  multi_operand_adder #(.WIDTH(8), .SIZE(9), .MODE(ARR_COMB)) uut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_c), .operands(ops_w),
    .out_valid(vld_c), .out_ready(out_ready), .sum(sum_c), .sum_a(sa_c), .sum_b(sb_c));
  multi_operand_adder #(.WIDTH(8), .SIZE(9), .MODE(ARR_CSA)) uut_csa (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_s), .operands(ops_w),
    .out_valid(vld_s), .out_ready(out_ready), .sum(sum_s), .sum_a(sa_s), .sum_b(sb_s));
  multi_operand_adder #(.WIDTH(2), .SIZE(5), .MODE(ARR_COMB)) uut_tiny (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_t), .operands(ops_t),
    .out_valid(vld_t), .out_ready(out_ready), .sum(sum_t), .sum_a(sa_t), .sum_b(sb_t));

  function automatic int ref_big(logic [71:0] v);
    int acc = 0;
    for (int i = 0; i < 9; i++) acc += int'(v[i*8 +: 8]);
    return acc;
  endfunction

  function automatic int ref_tiny(logic [9:0] v);
    int acc = 0;
    for (int i = 0; i < 5; i++) acc += int'(v[i*2 +: 2]);
    return acc;
  endfunction

  function automatic int bits_needed(int maxv);
    int b = 0;
    while ((longint'(1) << b) <= longint'(maxv)) b++;
    return b;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Present one operand set, let the rising-edge slot take it, then check every variant.
  task automatic send(logic [71:0] w, logic [9:0] t);
    int eb, et;
    eb = ref_big(w);
    et = ref_tiny(t);
    @(posedge clk);
    #2 ops_w = w; ops_t = t; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 comb sum", int'(sum_c), eb);
    chk("R1 tiny comb sum", int'(sum_t), et);
    chk("R3 comb out_valid", int'(vld_c), 1);
    chk("R4 pipe sum", int'(sum_p), eb);
    chk("R4 pipe out_valid", int'(vld_p), 1);
    chk("R9 falling pipe sum", int'(sum_f), eb);
    chk("R7 redundant pair", int'(sa_s) + int'(sb_s), eb);
    chk("R8 redundant sum zero", int'(sum_s), 0);
    chk("R8 pipe rows zero", int'(sa_p) | int'(sb_p) | int'(sa_c) | int'(sb_c), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end

  initial begin
    logic [95:0] r;
    logic [71:0] a_set, b_set;
    void'($urandom(32'd5150));

    // R10: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R10 out_valid in reset", int'(vld_p), 0);
    chk("R10 in_ready in reset", int'(rdy_p), 1);
    #1 rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R10 out_valid after reset", int'(vld_p), 0);
    chk("R10 falling out_valid after reset", int'(vld_f), 0);

    // R2: output widths
    chk("R2 width 8x9", $bits(uut.sum), bits_needed(9 * 255));
    chk("R2 width 2x5", $bits(uut_tiny.sum), bits_needed(5 * 3));
    chk("R2 redundant width", $bits(uut_csa.sum_a), bits_needed(9 * 255));

    // Directed corners
    send({72{1'b1}}, {10{1'b1}});               // R2 all ones: 2295 and 15
    send('0, '0);
    send({64'h0, 8'hFF}, 10'b11_0000_0000);       // one full-scale operand
    send({8'hFF, 64'h0}, 10'b00_0000_0011);
    send({9{8'hAA}}, {5{2'b10}});
    send({9{8'h55}}, {5{2'b01}});

    // Random operand sets
    for (int n = 0; n < 60; n++) begin
      r = {$urandom(), $urandom(), $urandom()};
      send(r[71:0], r[81:72]);
    end

    // R5: stall with a held result and new data waiting
    a_set = {9{8'h05}};
    b_set = {9{8'h10}};
    send(a_set, 10'h0);
    #1 out_ready = 1'b0; ops_w = b_set; in_valid = 1'b1;
    #1 chk("R5 in_ready low on stall", int'(rdy_p), 0);
    @(posedge clk);
    #1;
    chk("R5 sum held", int'(sum_p), ref_big(a_set));
    chk("R5 out_valid held", int'(vld_p), 1);
    #1 out_ready = 1'b1;
    #1 chk("R5 in_ready back", int'(rdy_p), 1);
    @(posedge clk);
    #1 chk("R5 waiting set taken", int'(sum_p), ref_big(b_set));

    // R9: falling-edge build updates half a cycle before the rising one
    @(posedge clk);
    #2 ops_w = {72{1'b1}};
    @(negedge clk);
    #1;
    chk("R9 falling slot updated", int'(sum_f), 2295);
    chk("R9 rising slot not yet", int'(sum_p), ref_big(b_set));
    @(posedge clk);
    #1 chk("R9 rising slot updated", int'(sum_p), 2295);

    // R6 and R3: drain and pass-through handshake
    #1 in_valid = 1'b0;
    @(posedge clk);
    #1;
    chk("R6 pipe drains", int'(vld_p), 0);
    chk("R6 falling pipe drains", int'(vld_f), 0);
    chk("R3 comb out_valid follows", int'(vld_c), 0);
    out_ready = 1'b0;
    #1;
    chk("R3 comb in_ready follows", int'(rdy_c), 0);
    chk("R3 redundant in_ready follows", int'(rdy_s), 0);
    chk("R5 empty slot ready", int'(rdy_p), 1);

    finish_run();
  end

endmodule